// File: doc/BRIEF.md
# External Asynchronous Write Sequencer

This block takes write requests from an internal request/ready port and plays each one out as one or more asynchronous strobe cycles on an external 16-bit memory or peripheral bus. A request carries a byte address, 32 bits of write data, an access size and a four-bit byte mask. The controller latches the request and timing settings when it accepts it. It then runs a setup phase, a strobe phase and a hold phase for every external access. During these phases it drives an active-low chip select, an active-low write enable, two active-low byte enables, a bank-select pair, the word address lines and the data bus with its driver enable.

A mode input picks a 16-bit or an 8-bit attached device. In 16-bit mode the halfword-select bit of the byte address goes out on the low bank-select pin, and the word address lines start at byte-address bit 2. A 32-bit write becomes two back-to-back accesses: the low halfword goes first and the high halfword second. In 8-bit mode every byte is its own access on the low byte lane. The request port is released only after the hold phase of the last access has finished.

Top module: `extbus_wr_ctrl`

## Requirements
- R1: Each external access runs setup for cfg_setup+1 cycles, then strobe for cfg_strobe+1 cycles, then hold for cfg_hold+1 cycles. ext_cs_n is low in all of these cycles.
- R2: ext_we_n is low only during the strobe phase. The address, bank, byte-enable and data outputs do not change while ext_we_n is low.
- R3: With cfg_wide=1, a word write (size 2'b10 or 2'b11) makes two complete accesses back to back. Between the two write-enable pulses there are (cfg_hold+1)+(cfg_setup+1) cycles, with chip select held low.
- R4: With cfg_wide=1, a halfword write (size 2'b01) makes exactly one write-enable pulse. It carries req_wdata[15:0], and ext_be_n equals ~req_be[1:0], so a full mask asserts both lanes.
- R5: With cfg_wide=1, ext_ba[0] carries byte-address bit 1, ext_ba[1] is 0, and ext_addr carries byte-address bits 2 and up. The second access of a word write uses the aligned byte address plus 2 (carry included), data req_wdata[31:16] and ext_be_n = ~req_be[3:2].
- R6: Byte-address bit 0 has no effect on the address, bank, enables or data of halfword and word writes.
- R7: With cfg_wide=1, a byte write (size 2'b00) asserts only the lane chosen by byte-address bit 0 (0 selects ext_be_n[0] and ext_dq_out[7:0]), gated by req_be[0]. The other lane's enable stays high, and req_wdata[7:0] appears on both lanes.
- R8: With cfg_wide=0, byte, halfword and word writes make 1, 2 and 4 accesses. Access k carries byte k of the data on both lanes, ext_be_n = {1, ~req_be[k]}, ext_ba = byte-address bits [1:0] and ext_addr = byte-address bits 2 and up. The byte address for access k is the request address plus k, with bit 0 cleared first for halfword and word sizes.
- R9: req_ready is high exactly when the controller is idle. It drops in the cycle after a request is accepted and rises in the cycle after the final hold phase.
- R10: A request presented while busy is ignored. Changes to cfg_wide, cfg_setup, cfg_strobe or cfg_hold after acceptance do not affect the transfer in progress.
- R11: ext_dq_oe is high from the first setup cycle to the last hold cycle and low while idle. While idle, ext_cs_n and ext_we_n are high, ext_be_n is 2'b11 and ext_dq_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, little-endian |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_be | input | 4 | Byte mask, bit k gates byte k |
| cfg_wide | input | 1 | 1: 16-bit device, 0: 8-bit device |
| cfg_setup | input | CNT_W | Setup count (phase is count+1 cycles) |
| cfg_strobe | input | CNT_W | Strobe count |
| cfg_hold | input | CNT_W | Hold count |
| ext_cs_n | output | 1 | Chip select, active low |
| ext_we_n | output | 1 | Write enable, active low |
| ext_be_n | output | 2 | Byte-lane enables, active low |
| ext_ba | output | 2 | Bank-select pins |
| ext_addr | output | ADDR_W-2 | Word address lines |
| ext_dq_out | output | 16 | Data bus value |
| ext_dq_oe | output | 1 | Data bus driver enable |

## Verification
The checker watches the cycle-level rules on every cycle. Write enable may only be low under chip select. The bus must stay stable during a strobe. Setup must start with write enable high and hold must follow the strobe. The data driver must follow chip select, idle byte enables must be high, and the ready handshake must drop after an accept. Only the bench scenarios can show the exact phase lengths, the two-access split and its gap, the halfword and byte-lane address mapping, the 8-bit mode byte sequence, and that busy-time requests and setting changes are ignored. The bench checks each of these cycle by cycle against its own model.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } ewc_phase_e;

   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;

   // number of external accesses for one request
   function automatic logic [2:0] ewc_beat_count(input logic wide, input logic [1:0] size);
      logic [2:0] n;
      if (wide) n = (size[1]) ? 3'd2 : 3'd1;
      else if (size == SZ_BYTE) n = 3'd1;
      else if (size == SZ_HALF) n = 3'd2;
      else n = 3'd4;
      return n;
   endfunction

endpackage

// File: rtl/ewc_phase_seq.sv
module ewc_phase_seq
   import ewc_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] setup_cnt,
   input  logic [CNT_W-1:0] strobe_cnt,
   input  logic [CNT_W-1:0] hold_cnt,
   input  logic [2:0]       nbeats,
   output ewc_phase_e       phase,
   output logic [1:0]       beat
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             phase_end;
   logic             last_beat;

   always_comb begin
      case (phase)
         PH_SETUP:  limit = setup_cnt;
         PH_STROBE: limit = strobe_cnt;
         PH_HOLD:   limit = hold_cnt;
         default:   limit = '0;
      endcase
   end

   assign phase_end = (cnt_q == limit);
   assign last_beat = ({1'b0, beat} == (nbeats - 3'd1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt_q <= '0;
         beat  <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               cnt_q <= '0;
               beat  <= '0;
               if (start) phase <= PH_SETUP;
            end
            PH_SETUP: begin
               if (phase_end) begin
                  phase <= PH_STROBE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_STROBE: begin
               if (phase_end) begin
                  phase <= PH_HOLD;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               if (phase_end) begin
                  cnt_q <= '0;
                  if (last_beat) begin
                     phase <= PH_IDLE;
                     beat  <= '0;
                  end else begin
                     phase <= PH_SETUP;
                     beat  <= beat + 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/ewc_beat_map.sv
module ewc_beat_map
   import ewc_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic              wide,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic [3:0]        mask,
   input  logic [1:0]        beat,
   output logic [1:0]        ba,
   output logic [ADDR_W-3:0] waddr,
   output logic [1:0]        be_n,
   output logic [15:0]       dq
);

   localparam int LANES = 2;

   logic [ADDR_W-1:0] base;
   logic [2:0]        step;
   logic [ADDR_W-1:0] badr;
   logic [3:0]        msh;
   logic [31:0]       half_sh;
   logic [31:0]       byte_sh;
   logic [LANES-1:0]  lane_on;

   // bit 0 is dropped for halfword and word sizes
   assign base  = (size == SZ_BYTE) ? addr : {addr[ADDR_W-1:1], 1'b0};
   assign step  = wide ? {beat, 1'b0} : {1'b0, beat};
   assign badr  = base + {{(ADDR_W-3){1'b0}}, step};

   assign ba    = wide ? {1'b0, badr[1]} : badr[1:0];
   assign waddr = badr[ADDR_W-1:2];

   assign msh     = mask  >> (wide ? {beat, 1'b0} : {1'b0, beat});
   assign half_sh = wdata >> {beat, 4'b0000};
   assign byte_sh = wdata >> {beat, 3'b000};

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         always_comb begin
            if (wide) begin
               if (size == SZ_BYTE)
                  lane_on[l] = (addr[0] == l[0]) && mask[0];
               else if (size == SZ_HALF)
                  lane_on[l] = mask[l];
               else
                  lane_on[l] = msh[l];
            end else begin
               lane_on[l] = (l == 0) && msh[0];
            end
         end
         assign be_n[l] = ~lane_on[l];
      end
   endgenerate

   always_comb begin
      if (wide && (size == SZ_BYTE)) dq = {wdata[7:0], wdata[7:0]};
      else if (wide)                 dq = half_sh[15:0];
      else                           dq = {byte_sh[7:0], byte_sh[7:0]};
   end

endmodule

// File: rtl/extbus_wr_ctrl.sv
module extbus_wr_ctrl
   import ewc_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   input  logic [1:0]        req_size,
   input  logic [3:0]        req_be,
   input  logic              cfg_wide,
   input  logic [CNT_W-1:0]  cfg_setup,
   input  logic [CNT_W-1:0]  cfg_strobe,
   input  logic [CNT_W-1:0]  cfg_hold,
   output logic              ext_cs_n,
   output logic              ext_we_n,
   output logic [1:0]        ext_be_n,
   output logic [1:0]        ext_ba,
   output logic [ADDR_W-3:0] ext_addr,
   output logic [15:0]       ext_dq_out,
   output logic              ext_dq_oe
);

   generate
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("extbus_wr_ctrl: ADDR_W must be at least 4");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("extbus_wr_ctrl: CNT_W must be at least 1");
      end
   endgenerate

   ewc_phase_e        phase;
   logic [1:0]        beat;
   logic              accept;
   logic              busy;

   logic              r_wide;
   logic [1:0]        r_size;
   logic [ADDR_W-1:0] r_addr;
   logic [31:0]       r_wdata;
   logic [3:0]        r_mask;
   logic [CNT_W-1:0]  r_setup;
   logic [CNT_W-1:0]  r_strobe;
   logic [CNT_W-1:0]  r_hold;
   logic [2:0]        nbeats;

   logic [1:0]        map_ba;
   logic [ADDR_W-3:0] map_addr;
   logic [1:0]        map_be_n;
   logic [15:0]       map_dq;

   assign busy   = (phase != PH_IDLE);
   assign accept = req_valid && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_wide   <= 1'b1;
         r_size   <= '0;
         r_addr   <= '0;
         r_wdata  <= '0;
         r_mask   <= '0;
         r_setup  <= '0;
         r_strobe <= '0;
         r_hold   <= '0;
      end else if (accept) begin
         r_wide   <= cfg_wide;
         r_size   <= req_size;
         r_addr   <= req_addr;
         r_wdata  <= req_wdata;
         r_mask   <= req_be;
         r_setup  <= cfg_setup;
         r_strobe <= cfg_strobe;
         r_hold   <= cfg_hold;
      end
   end

   assign nbeats = ewc_beat_count(r_wide, r_size);

   ewc_phase_seq #(.CNT_W(CNT_W)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .setup_cnt  (r_setup),
      .strobe_cnt (r_strobe),
      .hold_cnt   (r_hold),
      .nbeats     (nbeats),
      .phase      (phase),
      .beat       (beat)
   );

   ewc_beat_map #(.ADDR_W(ADDR_W)) map_i (
      .wide  (r_wide),
      .size  (r_size),
      .addr  (r_addr),
      .wdata (r_wdata),
      .mask  (r_mask),
      .beat  (beat),
      .ba    (map_ba),
      .waddr (map_addr),
      .be_n  (map_be_n),
      .dq    (map_dq)
   );

   assign req_ready  = !busy;
   assign ext_cs_n   = !busy;
   assign ext_we_n   = (phase != PH_STROBE);
   assign ext_dq_oe  = busy;
   assign ext_be_n   = busy ? map_be_n : 2'b11;
   assign ext_dq_out = busy ? map_dq   : 16'h0000;
   assign ext_ba     = map_ba;
   assign ext_addr   = map_addr;

endmodule

// File: rtl/extbus_wr_ctrl_chk.sv
module extbus_wr_ctrl_chk #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              ext_cs_n,
   input logic              ext_we_n,
   input logic [1:0]        ext_be_n,
   input logic [1:0]        ext_ba,
   input logic [ADDR_W-3:0] ext_addr,
   input logic [15:0]       ext_dq_out,
   input logic              ext_dq_oe
);

   // R2
   we_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_we_n |-> !ext_cs_n);

   // R2
   strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_we_n && $past(!ext_we_n)) |->
         ($stable(ext_addr) && $stable(ext_ba) && $stable(ext_be_n) && $stable(ext_dq_out)));

   // R1
   setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_cs_n) |-> ext_we_n);

   // R1
   hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_we_n) |-> !ext_cs_n);

   // R11
   driver_follows_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_dq_oe != ext_cs_n);

   // R11
   idle_lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_cs_n |-> (ext_be_n == 2'b11 && ext_dq_out == 16'h0000));

   // R9
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && !ext_cs_n));

   // R9
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> ext_cs_n);

endmodule

bind extbus_wr_ctrl extbus_wr_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .ext_cs_n   (ext_cs_n),
   .ext_we_n   (ext_we_n),
   .ext_be_n   (ext_be_n),
   .ext_ba     (ext_ba),
   .ext_addr   (ext_addr),
   .ext_dq_out (ext_dq_out),
   .ext_dq_oe  (ext_dq_oe)
);

// File: tb/extbus_wr_ctrl_tb_top.sv
`timescale 1ns/1ps
module extbus_wr_ctrl_tb_top;

   localparam int ADDR_W = 24;
   localparam int CNT_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic              req_ready;
   logic [ADDR_W-1:0] req_addr;
   logic [31:0]       req_wdata;
   logic [1:0]        req_size;
   logic [3:0]        req_be;
   logic              cfg_wide;
   logic [CNT_W-1:0]  cfg_setup, cfg_strobe, cfg_hold;
   logic              ext_cs_n, ext_we_n, ext_dq_oe;
   logic [1:0]        ext_be_n, ext_ba;
   logic [ADDR_W-3:0] ext_addr;
   logic [15:0]       ext_dq_out;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   extbus_wr_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_size(req_size), .req_be(req_be),
      .cfg_wide(cfg_wide), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
      .ext_cs_n(ext_cs_n), .ext_we_n(ext_we_n), .ext_be_n(ext_be_n), .ext_ba(ext_ba),
      .ext_addr(ext_addr), .ext_dq_out(ext_dq_out), .ext_dq_oe(ext_dq_oe)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int exp_beats(input logic wide, input logic [1:0] sz);
      if (wide) return (sz[1]) ? 2 : 1;
      return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
   endfunction

   function automatic logic [ADDR_W-1:0] exp_badr(input logic wide, input logic [1:0] sz,
                                                  input logic [ADDR_W-1:0] a, input int k);
      logic [ADDR_W-1:0] b;
      b = (sz == 2'b00) ? a : (a & ~{{(ADDR_W-1){1'b0}}, 1'b1});
      return b + ADDR_W'(wide ? 2 * k : k);
   endfunction

   function automatic logic [1:0] exp_be_n(input logic wide, input logic [1:0] sz,
                                           input logic [ADDR_W-1:0] a, input logic [3:0] m, input int k);
      if (!wide) return {1'b1, ~m[k]};
      if (sz == 2'b00) return a[0] ? {~m[0], 1'b1} : {1'b1, ~m[0]};
      if (sz == 2'b01) return ~m[1:0];
      return (k == 0) ? ~m[1:0] : ~m[3:2];
   endfunction

   function automatic logic [15:0] exp_dq(input logic wide, input logic [1:0] sz,
                                          input logic [31:0] d, input int k);
      logic [7:0] b;
      if (wide && sz == 2'b00) return {d[7:0], d[7:0]};
      if (wide) return (k == 0) ? d[15:0] : d[31:16];
      b = d[8*k +: 8];
      return {b, b};
   endfunction

   // one request, traced cycle by cycle; poke drives junk requests and settings while busy
   task automatic run_txn(input logic wide, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                          input logic [31:0] d, input logic [3:0] m,
                          input int s, input int t, input int h, input bit poke);
      int nb;
      logic [ADDR_W-1:0] b;
      @(negedge clk);
      cfg_wide = wide; cfg_setup = CNT_W'(s); cfg_strobe = CNT_W'(t); cfg_hold = CNT_W'(h);
      req_addr = a; req_wdata = d; req_size = sz; req_be = m; req_valid = 1'b1;
      chk("R9", "ready before accept", 32'(req_ready), 32'd1);
      @(negedge clk);
      if (poke) begin
         // R10: junk request and new settings during the transfer
         req_addr = ~a; req_wdata = ~d; req_size = ~sz; req_be = ~m;
         cfg_wide = ~wide; cfg_setup = CNT_W'(s + 3); cfg_strobe = CNT_W'(t + 5); cfg_hold = CNT_W'(h + 2);
      end else begin
         req_valid = 1'b0;
      end
      nb = exp_beats(wide, sz);
      for (int k = 0; k < nb; k++) begin
         b = exp_badr(wide, sz, a, k);
         for (int p = 0; p < 3; p++) begin
            int len;
            len = (p == 0) ? s + 1 : (p == 1) ? t + 1 : h + 1;
            for (int c = 0; c < len; c++) begin
               chk("R1", "cs_n in access", 32'(ext_cs_n), 32'd0);
               chk((k == 1 && wide) ? "R3" : "R2", "we_n phase", 32'(ext_we_n), (p == 1) ? 32'd0 : 32'd1);
               chk("R9", "ready while busy", 32'(req_ready), 32'd0);
               chk("R11", "dq_oe while busy", 32'(ext_dq_oe), 32'd1);
               chk(wide ? "R5" : "R8", "ba", 32'(ext_ba), wide ? {30'd0, 1'b0, b[1]} : {30'd0, b[1:0]});
               chk(wide ? "R5" : "R8", "addr", 32'(ext_addr), 32'(b[ADDR_W-1:2]));
               chk(wide ? ((sz == 2'b00) ? "R7" : "R4") : "R8", "be_n", 32'(ext_be_n),
                   32'(exp_be_n(wide, sz, a, m, k)));
               chk(wide ? ((sz == 2'b00) ? "R7" : "R6") : "R8", "dq", 32'(ext_dq_out),
                   32'(exp_dq(wide, sz, d, k)));
               @(negedge clk);
            end
         end
      end
      req_valid = 1'b0;
      chk(poke ? "R10" : "R9", "ready after last hold", 32'(req_ready), 32'd1);
      chk("R11", "cs_n idle", 32'(ext_cs_n), 32'd1);
      chk("R11", "we_n idle", 32'(ext_we_n), 32'd1);
      chk("R11", "dq_oe idle", 32'(ext_dq_oe), 32'd0);
      chk("R11", "be_n idle", 32'(ext_be_n), 32'd3);
      chk("R11", "dq idle", 32'(ext_dq_out), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd20240611);
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_wdata = '0; req_size = '0; req_be = '0;
      cfg_wide = 1'b1; cfg_setup = '0; cfg_strobe = '0; cfg_hold = '0;
      repeat (3) @(negedge clk);
      chk("R11", "reset cs_n", 32'(ext_cs_n), 32'd1);
      chk("R11", "reset we_n", 32'(ext_we_n), 32'd1);
      chk("R11", "reset dq_oe", 32'(ext_dq_oe), 32'd0);
      chk("R9", "reset ready", 32'(req_ready), 32'd1);
      rst_n = 1'b1;

      // R4: halfword, full mask, one pulse
      run_txn(1'b1, 2'b01, 24'h001000, 32'h0000_1234, 4'hF, 1, 2, 1, 1'b0);
      // R6: same halfword with bit 0 set
      run_txn(1'b1, 2'b01, 24'h001001, 32'h0000_1234, 4'hF, 1, 2, 1, 1'b0);
      // R3 / R5: word at halfword offset 2, carry into the word address
      run_txn(1'b1, 2'b10, 24'h001002, 32'hCAFE_5678, 4'hF, 2, 1, 3, 1'b0);
      // R6: word with bit 0 set, partial mask
      run_txn(1'b1, 2'b11, 24'h000101, 32'hA5A5_0F0F, 4'b1011, 0, 0, 0, 1'b0);
      // R7: byte lanes
      run_txn(1'b1, 2'b00, 24'h000010, 32'h0000_00AB, 4'h1, 0, 1, 0, 1'b0);
      run_txn(1'b1, 2'b00, 24'h000013, 32'h0000_00CD, 4'h1, 0, 1, 0, 1'b0);
      // R8: 8-bit device, word split into four bytes
      run_txn(1'b0, 2'b10, 24'h000203, 32'h4433_2211, 4'b0111, 1, 0, 1, 1'b0);
      // R1: longest phases
      run_txn(1'b1, 2'b10, 24'hFFFFFE, 32'h1357_9BDF, 4'hF, 15, 15, 15, 1'b0);
      // R10: junk while busy
      run_txn(1'b1, 2'b10, 24'h000400, 32'hDEAD_BEEF, 4'hF, 1, 1, 1, 1'b1);

      for (int i = 0; i < 60; i++) begin
         run_txn(1'($urandom), 2'($urandom), ADDR_W'($urandom), $urandom, 4'($urandom),
                 int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 3)), 1'($urandom));
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule